// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects maskable interrupt requests from many peripherals and a small set of non-maskable trap requests, and turns them into one request toward a CPU. Each maskable source has a 3-bit priority. The source with the highest priority wins. When several sources share that priority, the one with the lower position wins. Traps always rank above every maskable source.

The block registers the winning vector number and the matching vector-table address. A single control input moves every fetch from the primary table to an alternate table with the same layout. A maskable source can only win when its priority is strictly above the CPU's current level. When the CPU acknowledges a request, the block retires that source and reports the level the CPU should run at.

Top module: `vic_ctrl`

## Requirements
- R1: A high bit on `irq_req_i` or `trap_req_i` at a clock edge sets that source's pending flag. The flag stays set until the source is retired by an acknowledge. If a request and the retiring acknowledge for the same source arrive at the same edge, the request wins and the flag stays set.
- R2: A pending maskable source i takes part in arbitration only when all of these hold: `irq_en_i[i]` is 1, its priority `irq_prio_i[3*i+2:3*i]` is non-zero, and that priority is strictly greater than `cpu_prio_i`. A source that is not eligible keeps its flag and wins as soon as it becomes eligible.
- R3: Among eligible maskable sources, the highest priority wins. Among equal priorities, the lowest source index wins.
- R4: A pending trap is requested whatever the value of `cpu_prio_i`, and it beats every maskable source. Among pending traps, the lowest trap index wins.
- R5: Trap k uses vector number k. Maskable source i uses vector number 8+i.
- R6: `vec_addr_o` equals base + 2 × `vec_num_o`. The base is 0x000004 when `alt_tbl_i` was 0 at the previous edge, and 0x000104 when it was 1.
- R7: `irq_o`, `vec_num_o` and `vec_addr_o` update exactly one clock edge after the request or input change that causes them. The latency does not depend on which source wins.
- R8: `ack_i` high while `irq_o` is 1 retires the presented source and loads `new_prio_o`. The value loaded is the source's priority for a maskable source, or 15−k for trap k. At the same edge the next winner is presented.
- R9: `ack_i` high while `irq_o` is 0 has no effect: `new_prio_o` and all pending flags are unchanged.
- R10: After reset, `irq_o` is 0, `new_prio_o` is 0 and every pending flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 26 | Maskable request pulses, one bit per source |
| irq_en_i | input | 26 | Per-source enable |
| irq_prio_i | input | 78 | Per-source 3-bit priority; source i occupies bits 3i+2..3i |
| trap_req_i | input | 4 | Non-maskable trap request pulses |
| cpu_prio_i | input | 4 | Current CPU priority level |
| alt_tbl_i | input | 1 | Use the alternate vector table |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_num_o | output | 6 | Vector number of the presented winner |
| vec_addr_o | output | 24 | Vector-table address to fetch |
| new_prio_o | output | 4 | CPU level loaded on acknowledge |

## Verification
The hardest case to reach from the ports is a source that is pending but not eligible, which must later win with no new request. Examples are a source masked by the CPU level, a disabled source, or a source at priority zero. The stimulus pulses the request while the source is blocked and checks that `irq_o` stays low. It then removes only the block (raises the priority, sets the enable, or lowers `cpu_prio_i`) and checks that the vector appears one edge later. Ordering cases use a chain of acknowledges through several pending sources, with traps mixed in. This shows the trap ordering and the fall-back to maskable winners.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W     = 3;
  localparam int LVL_W      = 4;
  localparam int TRAP_SLOTS = 8;
  localparam int ADDR_W     = 24;
  localparam logic [ADDR_W-1:0] PRI_BASE = 24'h000004;
  localparam logic [ADDR_W-1:0] ALT_BASE = 24'h000104;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] pend_q;

  // set has priority over retire
  assign nxt_o = (pend_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= nxt_o;

  p_set_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
  p_clear_takes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int N      = 26,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      elig_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PRIO_W-1:0] prio_o
);
  // descending scan with >= leaves the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i] && prio_i[i*PRIO_W +: PRIO_W] >= prio_o) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_best_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_i[g] |-> (valid_o && prio_i[g*PRIO_W +: PRIO_W] <= prio_o));
    p_tie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig_i[g] && prio_i[g*PRIO_W +: PRIO_W] == prio_o) |-> (idx_o <= IDX_W'(g)));
  end
endmodule

// File: rtl/vic_vec.sv
module vic_vec
  import vic_pkg::*;
#(
  parameter int VEC_W = 6
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              alt_i,
  output logic [ADDR_W-1:0] addr_o
);
  // two address units per table entry
  assign addr_o = (alt_i ? ALT_BASE : PRI_BASE) + ADDR_W'({vec_i, 1'b0});
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int N_IRQ  = 26,
  parameter int N_TRAP = 4,
  localparam int VEC_W  = $clog2(TRAP_SLOTS + N_IRQ),
  localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int TOP_LVL = (1 << LVL_W) - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IRQ-1:0]        irq_req_i,
  input  logic [N_IRQ-1:0]        irq_en_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [N_TRAP-1:0]       trap_req_i,
  input  logic [LVL_W-1:0]        cpu_prio_i,
  input  logic                    alt_tbl_i,
  input  logic                    ack_i,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        vec_num_o,
  output logic [ADDR_W-1:0]       vec_addr_o,
  output logic [LVL_W-1:0]        new_prio_o
);
  logic                irq_q, alt_q, ack_take;
  logic [VEC_W-1:0]    vec_q, vec_d;
  logic [LVL_W-1:0]    lvl_q, lvl_d, np_q;
  logic [N_IRQ-1:0]    irq_clr, irq_nxt, elig;
  logic [N_TRAP-1:0]   trap_clr, trap_nxt;
  logic                arb_valid;
  logic [IDX_W-1:0]    arb_idx;
  logic [PRIO_W-1:0]   arb_prio;
  logic                trap_any;
  logic [VEC_W-1:0]    trap_vec;
  logic [LVL_W-1:0]    trap_lvl;

  assign ack_take = ack_i & irq_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign irq_clr[i] = ack_take && (vec_q == VEC_W'(TRAP_SLOTS + i));
    assign elig[i]    = irq_nxt[i] && irq_en_i[i]
                        && (irq_prio_i[i*PRIO_W +: PRIO_W] != '0)
                        && (LVL_W'(irq_prio_i[i*PRIO_W +: PRIO_W]) > cpu_prio_i);
  end
  for (genvar k = 0; k < N_TRAP; k++) begin : g_trap
    assign trap_clr[k] = ack_take && (vec_q == VEC_W'(k));
  end

  vic_pend #(.W(N_IRQ)) u_irq_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_req_i), .clr_i(irq_clr), .nxt_o(irq_nxt));
  vic_pend #(.W(N_TRAP)) u_trap_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(trap_req_i), .clr_i(trap_clr), .nxt_o(trap_nxt));

  vic_arb #(.N(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .elig_i(elig), .prio_i(irq_prio_i),
    .valid_o(arb_valid), .idx_o(arb_idx), .prio_o(arb_prio));

  // lowest pending trap; trap k runs at level TOP_LVL-k
  always_comb begin
    trap_any = 1'b0;
    trap_vec = '0;
    trap_lvl = '0;
    for (int k = N_TRAP - 1; k >= 0; k--) begin
      if (trap_nxt[k]) begin
        trap_any = 1'b1;
        trap_vec = VEC_W'(k);
        trap_lvl = LVL_W'(TOP_LVL - k);
      end
    end
  end

  always_comb begin
    if (trap_any) begin
      vec_d = trap_vec;
      lvl_d = trap_lvl;
    end else if (arb_valid) begin
      vec_d = VEC_W'(TRAP_SLOTS) + VEC_W'(arb_idx);
      lvl_d = LVL_W'(arb_prio);
    end else begin
      vec_d = '0;
      lvl_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
      alt_q <= 1'b0;
      np_q  <= '0;
    end else begin
      irq_q <= trap_any | arb_valid;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
      alt_q <= alt_tbl_i;
      if (ack_take) np_q <= lvl_q;
    end
  end

  vic_vec #(.VEC_W(VEC_W)) u_vec (.vec_i(vec_q), .alt_i(alt_q), .addr_o(vec_addr_o));

  assign irq_o      = irq_q;
  assign vec_num_o  = vec_q;
  assign new_prio_o = np_q;

  p_above_cpu_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vec_num_o >= VEC_W'(TRAP_SLOTS)) |-> (lvl_q > $past(cpu_prio_i)));
  p_trap_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trap_nxt) |=> (irq_o && vec_num_o < VEC_W'(TRAP_SLOTS)));
  p_idle_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> $stable(new_prio_o));
endmodule

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [25:0] irq_req = '0, irq_en = '0;
  logic [25:0][2:0] prio_p = '0;
  logic [3:0]  trap_req = '0;
  logic [3:0]  cpu_prio = '0;
  logic        alt = 1'b0, ack = 1'b0;
  logic        irq;
  logic [5:0]  vec;
  logic [23:0] addr;
  logic [3:0]  new_prio;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vic_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .irq_prio_i(prio_p), .trap_req_i(trap_req), .cpu_prio_i(cpu_prio),
    .alt_tbl_i(alt), .ack_i(ack), .irq_o(irq), .vec_num_o(vec),
    .vec_addr_o(addr), .new_prio_o(new_prio));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_irq(int i);
    irq_req[i] = 1'b1; step(); irq_req[i] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 irq", irq, 0);
    check("R10 new_prio", new_prio, 0);
  endtask

  task automatic t_single();
    irq_en[3] = 1; prio_p[3] = 3'd4;
    irq_req[3] = 1'b1;
    check("R7 before edge", irq, 0);
    step(); irq_req[3] = 1'b0;
    check("R7 irq after one edge", irq, 1);
    check("R5 vec", vec, 11);
    check("R6 primary addr", addr, 24'h1A);
    step();
    check("R1 flag held", irq, 1);
    do_ack();
    check("R8 new_prio", new_prio, 4);
    check("R8 retired", irq, 0);
  endtask

  task automatic t_order();
    irq_en[2] = 1; irq_en[5] = 1; irq_en[7] = 1;
    prio_p[2] = 3'd5; prio_p[5] = 3'd5; prio_p[7] = 3'd6;
    irq_req[2] = 1; irq_req[5] = 1; step(); irq_req[2] = 0; irq_req[5] = 0;
    check("R3 tie low index", vec, 10);
    pulse_irq(7);
    check("R3 higher prio", vec, 15);
    do_ack();
    check("R8 new_prio 6", new_prio, 6);
    check("R8 next winner", vec, 10);
    do_ack();
    check("R3 remaining", vec, 13);
    do_ack();
    check("R8 drained", irq, 0);
  endtask

  task automatic t_mask();
    cpu_prio = 4'd5; irq_en[1] = 1; prio_p[1] = 3'd5;
    pulse_irq(1);
    check("R2 equal cpu level masks", irq, 0);
    prio_p[1] = 3'd6; step();
    check("R2 above cpu", irq, 1);
    check("R2 vec", vec, 9);
    do_ack();
    check("R8 new_prio", new_prio, 6);
    cpu_prio = 4'd0;
  endtask

  task automatic t_disable();
    irq_en[4] = 0; prio_p[4] = 3'd3;
    pulse_irq(4);
    check("R2 disabled", irq, 0);
    irq_en[4] = 1; step();
    check("R2 enabled later", vec, 12);
    check("R2 enabled irq", irq, 1);
    do_ack();
    irq_en[6] = 1; prio_p[6] = 3'd0;
    pulse_irq(6);
    check("R2 prio zero", irq, 0);
    prio_p[6] = 3'd1; step();
    check("R2 prio raised", vec, 14);
    do_ack();
    check("R8 new_prio 1", new_prio, 1);
  endtask

  task automatic t_trap();
    cpu_prio = 4'd7; irq_en[0] = 1; prio_p[0] = 3'd7;
    pulse_irq(0);
    check("R2 masked at 7", irq, 0);
    trap_req[2] = 1; step(); trap_req[2] = 0;
    check("R4 trap ignores cpu", irq, 1);
    check("R5 trap vec", vec, 2);
    check("R6 trap addr", addr, 24'h08);
    do_ack();
    check("R8 trap level", new_prio, 13);
    check("R4 no maskable", irq, 0);
    cpu_prio = 4'd6; step();
    check("R2 unmasked", vec, 8);
    do_ack();
    check("R8 level 7", new_prio, 7);
    cpu_prio = 4'd0;
  endtask

  task automatic t_trap_order();
    irq_en[2] = 1; prio_p[2] = 3'd7;
    trap_req[1] = 1; trap_req[3] = 1; irq_req[2] = 1; step();
    trap_req = '0; irq_req[2] = 0;
    check("R4 low trap wins", vec, 1);
    do_ack();
    check("R8 trap1 level", new_prio, 14);
    check("R4 next trap", vec, 3);
    do_ack();
    check("R8 trap3 level", new_prio, 12);
    check("R4 then maskable", vec, 10);
    do_ack();
    check("R8 drained", irq, 0);
  endtask

  task automatic t_alt();
    alt = 1; irq_en[25] = 1; prio_p[25] = 3'd2;
    pulse_irq(25);
    check("R5 last vec", vec, 33);
    check("R6 alt addr", addr, 24'h146);
    alt = 0; step();
    check("R6 back to primary", addr, 24'h46);
    do_ack();
    check("R8 new_prio 2", new_prio, 2);
  endtask

  task automatic t_ack_idle();
    do_ack();
    check("R9 level kept", new_prio, 2);
    check("R9 irq low", irq, 0);
    pulse_irq(3);
    irq_req[3] = 1; ack = 1; step(); irq_req[3] = 0; ack = 0;
    check("R1 request beats retire", irq, 1);
    check("R1 vec", vec, 11);
    check("R8 level loaded", new_prio, 4);
    do_ack();
    check("R1 retired", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_mask();
    t_disable();
    t_trap();
    t_trap_order();
    t_alt();
    t_ack_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule